// File: doc/BRIEF.md
# Lock-Aware Multithreaded Issue Scheduler

This block picks which of four hardware threads sends the next instruction into a single-issue, in-order, five-stage pipeline. When all four threads can run, strict rotation spaces the instructions of any one thread four cycles apart, so no dependence check is needed. Threads that are blocked on a software lock are parked, and rotation carries on over the threads that are left. As fewer threads remain, the same thread can come round again while its producer is still in flight. Data hazards are then enforced from a small distance field that the compiler places beside each instruction, not by comparing register numbers.

Every thread presents a 4-bit metadata nibble for the instruction at its head. The nibble holds a lock flag, an unlock flag and a 2-bit hazard distance. The scheduler keeps a down-counter per thread, loaded from that distance when the thread issues. A thread may issue only when its counter is zero and it is not parked. The lock logic around the block drives per-thread suspend requests and wake pulses. The chosen thread, or a bubble, is registered onto the issue outputs together with the lock and unlock flags of the chosen instruction.

Top module: `thr_issue_sched`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the issue outputs are all zero. All threads then start unparked, with zero counters and the rotation pointer on thread 0.
- R2: With every thread eligible and every hazard distance zero, the issued threads follow the order 0, 1, 2, 3, 0, and so on.
- R3: The pick is the first eligible thread found from the rotation pointer upward, wrapping from 3 to 0. After an issue, the pointer moves to the thread after the one that issued.
- R4: A suspend request for a thread parks it from the next cycle on, and a parked thread is never issued.
- R5: A wake pulse for a parked thread makes it eligible in the next cycle, provided its counter is zero. It then takes its usual place in the rotation.
- R6: Metadata bits [1:0] are the hazard distance d. After a thread issues with distance d, it does not issue again for d cycles, and it is eligible again on the cycle after that. So d = 2 makes a gap of three cycles between issues.
- R7: When no thread is eligible, a bubble goes out (issue valid low, both flags low) and the rotation pointer does not move.
- R8: Metadata bit 3 is the lock flag and bit 2 is the unlock flag. Each is copied to the issue outputs together with the thread that issues.
- R9: The pick made in a cycle appears on the issue outputs after exactly one clock edge.
- R10: If a suspend request and a wake pulse reach the same thread in the same cycle, the wake wins and the thread is not parked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| meta_i | input | 16 | Head-instruction metadata, 4 bits per thread, thread k at [4k+3:4k] |
| susp_req_i | input | 4 | Per-thread request to park the thread |
| wake_i | input | 4 | Per-thread pulse to unpark the thread |
| issue_vld_o | output | 1 | An instruction issues this cycle (low means bubble) |
| issue_tid_o | output | 2 | Thread that issued; holds its last value during a bubble |
| issue_lock_o | output | 1 | Lock flag of the issued instruction |
| issue_unlock_o | output | 1 | Unlock flag of the issued instruction |

## Verification
The assertions assume that `meta_i`, `susp_req_i` and `wake_i` are never unknown and are settled before each rising edge. They also assume that the metadata of a thread describes the instruction that would issue for it in that cycle. The hazard-gap properties depend on this, because they read the distance of the thread that is picked. The stimulus drives every input on the falling edge from fixed values or from a deterministic generator, so no input is ever left undriven. The assertions check the parking, waking, bubble and gap behaviour against any input pattern within these limits.

// File: rtl/thr_sched_pkg.sv
`timescale 1ns/1ps
package thr_sched_pkg;
  parameter int unsigned HAZ_W      = 2;
  parameter int unsigned META_W     = HAZ_W + 2;
  parameter int unsigned LOCK_BIT   = META_W - 1;
  parameter int unsigned UNLOCK_BIT = META_W - 2;
endpackage

// File: rtl/thr_ctx.sv
`timescale 1ns/1ps
// Per-thread context: earliest-issue down-counter and parked flag.
module thr_ctx
  import thr_sched_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_i,
  input  logic [HAZ_W-1:0] haz_i,
  input  logic             susp_req_i,
  input  logic             wake_i,
  output logic             elig_o,
  output logic             susp_o
);
  logic [HAZ_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             susp_q, susp_d;
  logic             susp_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (issue_i) begin
      cnt_d  = haz_i;
      cnt_en = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_d  = cnt_q - HAZ_W'(1);
      cnt_en = 1'b1;
    end
  end

  always_comb begin
    susp_d  = susp_q;
    susp_en = wake_i | susp_req_i;
    if (wake_i)          susp_d = 1'b0;
    else if (susp_req_i) susp_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      susp_q <= 1'b0;
    end else begin
      if (cnt_en)  cnt_q  <= cnt_d;
      if (susp_en) susp_q <= susp_d;
    end
  end

  assign elig_o = (cnt_q == '0) && !susp_q;
  assign susp_o = susp_q;
endmodule

// File: rtl/rr_pick.sv
`timescale 1ns/1ps
// Rotating-priority selector: first eligible thread at or after the pointer.
module rr_pick #(
  parameter int unsigned NTHR  = 4,
  parameter int unsigned TID_W = $clog2(NTHR)
) (
  input  logic [NTHR-1:0]  elig_i,
  input  logic [TID_W-1:0] ptr_i,
  output logic             vld_o,
  output logic [TID_W-1:0] tid_o
);
  always_comb begin
    int idx;
    vld_o = 1'b0;
    tid_o = ptr_i;
    for (int i = NTHR - 1; i >= 0; i--) begin
      idx = (int'(ptr_i) + i) % NTHR;
      if (elig_i[idx]) begin
        vld_o = 1'b1;
        tid_o = TID_W'(idx);
      end
    end
  end
endmodule

// File: rtl/thr_issue_sched.sv
`timescale 1ns/1ps
module thr_issue_sched
  import thr_sched_pkg::*;
#(
  parameter int unsigned NTHR = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NTHR*META_W-1:0]     meta_i,
  input  logic [NTHR-1:0]            susp_req_i,
  input  logic [NTHR-1:0]            wake_i,
  output logic                       issue_vld_o,
  output logic [$clog2(NTHR)-1:0]    issue_tid_o,
  output logic                       issue_lock_o,
  output logic                       issue_unlock_o
);
  localparam int unsigned TID_W = $clog2(NTHR);

  logic [NTHR-1:0]  elig;
  logic [NTHR-1:0]  susp_q;
  logic [NTHR-1:0]  pick_oh;
  logic             pick_vld;
  logic [TID_W-1:0] pick_tid;
  logic [TID_W-1:0] ptr_q, ptr_d;
  logic             pick_lock, pick_unlock;

  for (genvar k = 0; k < NTHR; k++) begin : g_thr
    assign pick_oh[k] = pick_vld && (pick_tid == TID_W'(k));
    thr_ctx u_ctx (
      .clk        (clk),
      .rst_n      (rst_n),
      .issue_i    (pick_oh[k]),
      .haz_i      (meta_i[k*META_W +: HAZ_W]),
      .susp_req_i (susp_req_i[k]),
      .wake_i     (wake_i[k]),
      .elig_o     (elig[k]),
      .susp_o     (susp_q[k])
    );
  end

  rr_pick #(.NTHR(NTHR), .TID_W(TID_W)) u_pick (
    .elig_i (elig),
    .ptr_i  (ptr_q),
    .vld_o  (pick_vld),
    .tid_o  (pick_tid)
  );

  assign pick_lock   = meta_i[int'(pick_tid)*META_W + LOCK_BIT];
  assign pick_unlock = meta_i[int'(pick_tid)*META_W + UNLOCK_BIT];

  always_comb begin
    ptr_d = ptr_q;
    if (pick_vld) begin
      if (pick_tid == TID_W'(NTHR - 1)) ptr_d = '0;
      else                              ptr_d = pick_tid + TID_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q          <= '0;
      issue_vld_o    <= 1'b0;
      issue_tid_o    <= '0;
      issue_lock_o   <= 1'b0;
      issue_unlock_o <= 1'b0;
    end else begin
      if (pick_vld) begin
        ptr_q       <= ptr_d;
        issue_tid_o <= pick_tid;
      end
      issue_vld_o    <= pick_vld;
      issue_lock_o   <= pick_vld & pick_lock;
      issue_unlock_o <= pick_vld & pick_unlock;
    end
  end
endmodule

// File: rtl/thr_issue_sched_chk.sv
`timescale 1ns/1ps
module thr_issue_sched_chk
  import thr_sched_pkg::*;
#(
  parameter int unsigned NTHR  = 4,
  parameter int unsigned TID_W = $clog2(NTHR)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [NTHR*META_W-1:0] meta_i,
  input logic [NTHR-1:0]        susp_req_i,
  input logic [NTHR-1:0]        wake_i,
  input logic [NTHR-1:0]        elig,
  input logic [NTHR-1:0]        susp_q,
  input logic                   pick_vld,
  input logic [TID_W-1:0]       pick_tid,
  input logic [TID_W-1:0]       ptr_q,
  input logic                   issue_vld_o
);
  // R4: a parked thread is never chosen
  a_r4_no_parked_pick: assert property (@(posedge clk) disable iff (!rst_n)
    pick_vld |-> !susp_q[pick_tid]);

  // R3: the pointer thread wins whenever it is eligible
  a_r3_ptr_first: assert property (@(posedge clk) disable iff (!rst_n)
    elig[ptr_q] |-> (pick_vld && pick_tid == ptr_q));

  // R7: a bubble leaves the pointer where it was
  a_r7_bubble_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    !pick_vld |=> $stable(ptr_q));

  // R9: the registered valid follows the pick by one edge
  a_r9_one_edge: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (issue_vld_o == $past(pick_vld)));

  for (genvar k = 0; k < NTHR; k++) begin : g_k
    // R4: suspend without wake parks the thread
    a_r4_parks: assert property (@(posedge clk) disable iff (!rst_n)
      (susp_req_i[k] && !wake_i[k]) |=> susp_q[k]);
    // R5 / R10: a wake always clears the parked flag
    a_r5_wake_clears: assert property (@(posedge clk) disable iff (!rst_n)
      wake_i[k] |=> !susp_q[k]);
    // R6: distance 1 blocks the next cycle
    a_r6_gap1: assert property (@(posedge clk) disable iff (!rst_n)
      (pick_vld && pick_tid == TID_W'(k) && meta_i[k*META_W +: HAZ_W] == HAZ_W'(1))
      |=> !(pick_vld && pick_tid == TID_W'(k)));
    // R6: distance 2 blocks the next two cycles
    a_r6_gap2: assert property (@(posedge clk) disable iff (!rst_n)
      (pick_vld && pick_tid == TID_W'(k) && meta_i[k*META_W +: HAZ_W] == HAZ_W'(2))
      |=> !(pick_vld && pick_tid == TID_W'(k)) ##1 !(pick_vld && pick_tid == TID_W'(k)));
  end
endmodule

bind thr_issue_sched thr_issue_sched_chk #(.NTHR(NTHR)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .meta_i      (meta_i),
  .susp_req_i  (susp_req_i),
  .wake_i      (wake_i),
  .elig        (elig),
  .susp_q      (susp_q),
  .pick_vld    (pick_vld),
  .pick_tid    (pick_tid),
  .ptr_q       (ptr_q),
  .issue_vld_o (issue_vld_o)
);

// File: tb/thr_issue_sched_bench.sv
`timescale 1ns/1ps
module thr_issue_sched_bench;
  localparam int NTHR = 4;
  localparam int MW   = 4;

  logic                 clk;
  logic                 rst_n;
  logic [NTHR*MW-1:0]   meta;
  logic [NTHR-1:0]      sreq, wake;
  logic                 vld, lk, ulk;
  logic [1:0]           tid;

  int    n_vec, n_bad;
  bit    done;
  int    m_cnt [NTHR];
  bit    m_susp[NTHR];
  int    m_ptr;
  bit    e_vld, e_lk, e_ulk;
  int    e_tid;
  string e_tag;
  logic [31:0] rnd;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  thr_issue_sched #(.NTHR(NTHR)) u_thr_issue_sched (
    .clk            (clk),
    .rst_n          (rst_n),
    .meta_i         (meta),
    .susp_req_i     (sreq),
    .wake_i         (wake),
    .issue_vld_o    (vld),
    .issue_tid_o    (tid),
    .issue_lock_o   (lk),
    .issue_unlock_o (ulk)
  );

  function automatic logic [NTHR*MW-1:0] rep(input logic [MW-1:0] m);
    return {NTHR{m}};
  endfunction

  // Check the outputs against the last expectation, then apply new inputs
  // and predict the next pick from the requirements.
  task automatic step(input logic [NTHR*MW-1:0] mt, input logic [NTHR-1:0] sr,
                      input logic [NTHR-1:0] wk, input string tag);
    int pk;
    int idx;
    @(negedge clk);
    n_vec++;
    if (vld !== e_vld || int'(tid) != e_tid || lk !== e_lk || ulk !== e_ulk) begin
      n_bad++;
      $display("FAIL %s: vld/tid/lock/unlock got %b/%0d/%b/%b exp %b/%0d/%b/%b",
               e_tag, vld, tid, lk, ulk, e_vld, e_tid, e_lk, e_ulk);
    end
    rst_n = 1'b1;
    meta  = mt;
    sreq  = sr;
    wake  = wk;
    pk = -1;
    for (int i = 0; i < NTHR; i++) begin
      idx = (m_ptr + i) % NTHR;
      if (pk < 0 && m_cnt[idx] == 0 && !m_susp[idx]) pk = idx;
    end
    if (pk >= 0) begin
      e_vld = 1'b1;
      e_tid = pk;
      e_lk  = mt[pk*MW+3];
      e_ulk = mt[pk*MW+2];
      m_ptr = (pk + 1) % NTHR;
    end else begin
      e_vld = 1'b0;
      e_lk  = 1'b0;
      e_ulk = 1'b0;
    end
    for (int k = 0; k < NTHR; k++) begin
      if (k == pk)            m_cnt[k] = int'(mt[k*MW +: 2]);
      else if (m_cnt[k] > 0)  m_cnt[k] = m_cnt[k] - 1;
      if (wk[k])      m_susp[k] = 1'b0;
      else if (sr[k]) m_susp[k] = 1'b1;
    end
    e_tag = tag;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL R9: watchdog expired, got no end exp end");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    n_vec = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; meta = '0; sreq = '0; wake = '0;
    for (int k = 0; k < NTHR; k++) begin m_cnt[k] = 0; m_susp[k] = 1'b0; end
    m_ptr = 0;
    e_vld = 1'b0; e_tid = 0; e_lk = 1'b0; e_ulk = 1'b0;
    e_tag = "R1 reset state";
    rnd = 32'h1234_5678;
    repeat (3) @(posedge clk);

    step('0, '0, '0, "R1 first pick after reset");
    repeat (8) step('0, '0, '0, "R2 full rotation");
    // thread3 lock, thread2 unlock, thread1 both, thread0 none
    repeat (8) step({4'b1000, 4'b0100, 4'b1100, 4'b0000}, '0, '0, "R8 flag copy");
    step('0, 4'b0110, '0, "R4 suspend 1 and 2");
    repeat (6) step('0, '0, '0, "R4 R3 skip parked");
    step(rep(4'b0010), 4'b1000, '0, "R6 park 3");
    repeat (8) step(rep(4'b0010), '0, '0, "R6 distance 2");
    repeat (6) step(rep(4'b0001), '0, '0, "R6 distance 1");
    step('0, 4'b0001, '0, "R7 park 0");
    repeat (4) step('0, '0, '0, "R7 bubble");
    step('0, '0, 4'b0100, "R5 wake 2");
    repeat (3) step('0, '0, '0, "R5 rejoin");
    step('0, 4'b0010, 4'b0010, "R10 wake beats suspend");
    repeat (3) step('0, '0, '0, "R10 thread 1 live");
    step('0, '0, 4'b1111, "R5 wake all");
    for (int c = 0; c < 4000; c++) begin
      rnd = rnd ^ (rnd << 13);
      rnd = rnd ^ (rnd >> 17);
      rnd = rnd ^ (rnd << 5);
      step(rnd[15:0], rnd[19:16] & rnd[23:20] & rnd[27:24],
           rnd[27:24] | rnd[31:28], "R9 R3 sweep");
    end
    step('0, '0, 4'b1111, "R9 final");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule